// File: doc/BRIEF.md
# Triple-Redundant Voter with Spare Substitution

This block sits behind three active copies of a protected module and one idle spare copy. On every cycle marked valid it takes the outputs of the three copies that occupy the vote slots and forms a two-out-of-three majority. It registers the voted word and reports which physical copy disagreed with the majority.

A per-copy counter tells a passing upset from a persistent fault. A copy that disagrees on more consecutive voted cycles than a programmable limit is declared hard-failed. A one-cycle indication then goes to a recovery controller. The first such copy is replaced in its vote slot by the spare, so that a full three-way vote is restored. A second hard failure cannot be repaired. It sets a sticky degraded flag. If the three voted values all differ, no majority exists: the output holds and an unrecoverable condition is latched. A slot map reports which physical copy sits in each slot.

The block cannot detect two copies that agree on the same wrong value. That value wins the vote and the correct copy is reported as the one that disagrees.

Top module: `tmr_spare_voter`

## Requirements
- R1: One cycle after a cycle with `in_valid` high and a majority present, `vote_out` carries the value shared by at least two slotted copies and `vote_valid` is 1.
- R2: `rep_mismatch` bit i (0,1,2 = copies A,B,C, 3 = spare) is 1, aligned with `vote_out`, only for the one slotted copy that differed from the majority; at most one bit is set, and a copy outside the vote is never flagged.
- R3: If the three slotted values all differ pairwise, `no_majority` is 1 in the next cycle, `vote_out` keeps its previous value, no mismatch bit is set and no mismatch counter changes.
- R4: A copy's consecutive-mismatch count clears on any majority cycle where it agrees. The copy is declared hard-failed on the mismatch that finds the count already equal to `fail_limit`, that is, the (`fail_limit`+1)-th in a row. A copy already declared failed is never declared again.
- R5: A hard-failure declaration gives `hard_fault` high for exactly one cycle, aligned with that copy's mismatch bit, with `hard_fault_id` holding the copy index coded as in R2.
- R6: `slot_map` holds the copy index of vote slot s in bits [2s+1:2s]; after reset it is 6'b10_01_00. The first hard failure writes index 3 (spare) into the failed copy's slot, and this takes effect from the next cycle.
- R7: Any later hard failure leaves `slot_map` unchanged and sets `degraded`, which stays 1 until reset.
- R8: `unrecoverable` becomes 1 on the cycle `no_majority` or `degraded` is first reported and stays 1 until reset.
- R9: A cycle with `in_valid` low gives `vote_valid`, `no_majority`, `hard_fault` and all mismatch bits 0 in the next cycle, holds `vote_out`, and leaves the counters unchanged.
- R10: While `rst_n` is low at a clock edge, all outputs go to 0 except `slot_map`, which goes to its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Copy outputs are valid this cycle |
| fail_limit | input | CW | Consecutive mismatches tolerated before hard failure |
| rep_a | input | DW | Output of copy A (index 0) |
| rep_b | input | DW | Output of copy B (index 1) |
| rep_c | input | DW | Output of copy C (index 2) |
| rep_spare | input | DW | Output of spare copy (index 3) |
| vote_out | output | DW | Registered majority value |
| vote_valid | output | 1 | vote_out updated from a valid cycle |
| rep_mismatch | output | 4 | Per-copy disagreement flags |
| no_majority | output | 1 | All three slotted values differed |
| hard_fault | output | 1 | One-cycle hard-failure indication |
| hard_fault_id | output | 2 | Copy index of the failed copy |
| degraded | output | 1 | Sticky: second hard failure, no spare left |
| unrecoverable | output | 1 | Sticky: vote could not be trusted |
| slot_map | output | 6 | Copy index per vote slot |

## Verification
The vote is tried with all copies agreeing on changing data, with a single dissenter placed in each slot in turn, and with all three values distinct. These patterns separate the majority choice, the slot-to-copy flag mapping and the hold-on-no-majority path. Runs of mismatches of exactly `fail_limit`, broken by one agreeing cycle, are contrasted with runs one longer. This pins the off-by-one of the failure decision and the clearing of the count. After substitution, garbage on the removed copy and two copies sharing a wrong value show that the spare really votes and that the removed copy is ignored. A limit of zero then forces a second failure into the degraded state.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the spare-substituting voter.
// Assumes four physical copies (three active, one spare) and three vote slots.
package tmr_pkg;
    localparam int NREP  = 4;
    localparam int NSLOT = 3;
    localparam int IDW   = 2;
    localparam int MAPW  = NSLOT * IDW;
    typedef logic [IDW-1:0] rep_id_t;
    localparam rep_id_t SPARE_ID = 2'd3;
    localparam logic [MAPW-1:0] MAP_RESET = {2'd2, 2'd1, 2'd0};
endpackage

// File: rtl/tmr_slot_mux.sv
// Routes the physical copy named in each slot-map field onto its vote slot.
// Assumes reps packed as {spare, C, B, A}, DW bits each.
module tmr_slot_mux
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NREP*DW-1:0]  reps,
    input  logic [MAPW-1:0]     slot_map,
    output logic [NSLOT*DW-1:0] slot_vals
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        rep_id_t sel;
        assign sel = slot_map[IDW*s +: IDW];
        // Select the copy assigned to slot s.
        always_comb begin
            slot_vals[DW*s +: DW] = reps[DW*int'(sel) +: DW];
        end
    end
endmodule

// File: rtl/tmr_majority.sv
// Combinational two-of-three vote over slot values; names the dissenting slot.
// Assumes nothing about copy identity; works purely on slots.
module tmr_majority #(
    parameter int DW = 8
) (
    input  logic [3*DW-1:0] slot_vals,
    output logic [DW-1:0]   maj,
    output logic [2:0]      dissent,
    output logic            no_maj
);
    logic [DW-1:0] va, vb, vc;
    logic eab, eac, ebc;
    assign va  = slot_vals[0 +: DW];
    assign vb  = slot_vals[DW +: DW];
    assign vc  = slot_vals[2*DW +: DW];
    assign eab = (va == vb);
    assign eac = (va == vc);
    assign ebc = (vb == vc);

    // Pick the majority word and the slot that disagrees with it.
    always_comb begin
        maj     = va;
        dissent = 3'b000;
        no_maj  = 1'b0;
        if (eab) begin
            dissent[2] = !eac;
        end else if (eac) begin
            dissent[1] = 1'b1;
        end else if (ebc) begin
            maj        = vb;
            dissent[0] = 1'b1;
        end else begin
            no_maj = 1'b1;
        end
    end
endmodule

// File: rtl/tmr_persist_ctr.sv
// Per-copy consecutive-mismatch counter separating soft upsets from hard faults.
// Assumes evt_valid is high only on majority cycles where this copy is slotted.
module tmr_persist_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic          evt_miss,
    input  logic [CW-1:0] limit,
    output logic          trip,
    output logic          faulty
);
    logic [CW-1:0] cnt;

    // Declare failure when a mismatch arrives with the count already at the limit.
    assign trip = evt_valid && evt_miss && !faulty && (cnt >= limit);

    // Count consecutive mismatches, clear on agreement, latch the failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            faulty <= 1'b0;
        end else if (evt_valid && !faulty) begin
            if (!evt_miss)  cnt    <= '0;
            else if (trip)  faulty <= 1'b1;
            else            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_spare_ctl.sv
// Owns the slot map: swaps the spare into the first failed copy's slot,
// and marks the block degraded on any later failure.
// Assumes at most one trip bit is high per cycle.
module tmr_spare_ctl
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREP-1:0] trip,
    output logic [MAPW-1:0] slot_map,
    output logic            spare_used,
    output logic            degraded,
    output logic            hard_fault,
    output rep_id_t         hard_fault_id
);
    logic    trip_any;
    rep_id_t trip_id;
    logic [NSLOT-1:0] slot_hit;

    assign trip_any = |trip;

    // Encode which copy tripped.
    always_comb begin
        trip_id = '0;
        for (int r = 0; r < NREP; r++) begin
            if (trip[r]) trip_id = rep_id_t'(r);
        end
    end

    // Find the slot that holds the tripped copy.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_hit[s] = (slot_map[IDW*s +: IDW] == trip_id);
        end
    end

    // Update the map, spare usage, degraded flag and the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_map      <= MAP_RESET;
            spare_used    <= 1'b0;
            degraded      <= 1'b0;
            hard_fault    <= 1'b0;
            hard_fault_id <= '0;
        end else begin
            hard_fault <= trip_any;
            if (trip_any) begin
                hard_fault_id <= trip_id;
                if (!spare_used) begin
                    spare_used <= 1'b1;
                    for (int s = 0; s < NSLOT; s++) begin
                        if (slot_hit[s]) slot_map[IDW*s +: IDW] <= SPARE_ID;
                    end
                end else begin
                    degraded <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_spare_voter.sv
// Top: three-slot majority voter over four copies with spare substitution.
// Assumes copy outputs are synchronous to clk; output and flags lag by one cycle.
module tmr_spare_voter
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] fail_limit,
    input  logic [DW-1:0] rep_a,
    input  logic [DW-1:0] rep_b,
    input  logic [DW-1:0] rep_c,
    input  logic [DW-1:0] rep_spare,
    output logic [DW-1:0] vote_out,
    output logic          vote_valid,
    output logic [3:0]    rep_mismatch,
    output logic          no_majority,
    output logic          hard_fault,
    output logic [1:0]    hard_fault_id,
    output logic          degraded,
    output logic          unrecoverable,
    output logic [5:0]    slot_map
);
    logic [NREP*DW-1:0]  reps;
    logic [NSLOT*DW-1:0] slot_vals;
    logic [DW-1:0]       maj;
    logic [2:0]          dissent;
    logic                no_maj;
    logic [NREP-1:0]     in_slot, phys_miss, trip, faulty;
    logic                spare_used;

    assign reps = {rep_spare, rep_c, rep_b, rep_a};

    tmr_slot_mux #(.DW(DW)) u_mux (
        .reps(reps), .slot_map(slot_map), .slot_vals(slot_vals)
    );

    tmr_majority #(.DW(DW)) u_vote (
        .slot_vals(slot_vals), .maj(maj), .dissent(dissent), .no_maj(no_maj)
    );

    // Translate slot dissent into physical-copy mismatch and slot membership.
    always_comb begin
        for (int r = 0; r < NREP; r++) begin
            in_slot[r]   = 1'b0;
            phys_miss[r] = 1'b0;
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_map[IDW*s +: IDW] == rep_id_t'(r)) begin
                    in_slot[r]   = 1'b1;
                    phys_miss[r] = phys_miss[r] | dissent[s];
                end
            end
        end
    end

    for (genvar r = 0; r < NREP; r++) begin : g_ctr
        tmr_persist_ctr #(.CW(CW)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .evt_valid(in_valid && !no_maj && in_slot[r]),
            .evt_miss(phys_miss[r]),
            .limit(fail_limit),
            .trip(trip[r]),
            .faulty(faulty[r])
        );
    end

    tmr_spare_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .trip(trip),
        .slot_map(slot_map), .spare_used(spare_used), .degraded(degraded),
        .hard_fault(hard_fault), .hard_fault_id(hard_fault_id)
    );

    // Register the voted word and its aligned flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_out     <= '0;
            vote_valid   <= 1'b0;
            rep_mismatch <= '0;
            no_majority  <= 1'b0;
        end else begin
            vote_valid   <= in_valid;
            rep_mismatch <= in_valid ? phys_miss : '0;
            no_majority  <= in_valid && no_maj;
            if (in_valid && !no_maj) vote_out <= maj;
        end
    end

    // Latch the unrecoverable condition: no majority or second hard failure.
    always_ff @(posedge clk) begin
        if (!rst_n) unrecoverable <= 1'b0;
        else if ((in_valid && no_maj) || ((|trip) && spare_used)) unrecoverable <= 1'b1;
    end
endmodule

// File: rtl/tmr_spare_voter_chk.sv
// Property checker for tmr_spare_voter, attached by bind.
module tmr_spare_voter_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] vote_out,
    input logic          vote_valid,
    input logic [3:0]    rep_mismatch,
    input logic          no_majority,
    input logic          hard_fault,
    input logic [1:0]    hard_fault_id,
    input logic          degraded,
    input logic          unrecoverable,
    input logic [5:0]    slot_map
);
    assert_one_dissenter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rep_mismatch));
    assert_hold_on_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        no_majority |-> (rep_mismatch == 4'b0) && (vote_out == $past(vote_out)));
    assert_fault_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hard_fault |-> rep_mismatch[hard_fault_id]);
    assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hard_fault && (hard_fault_id != 2'd3) |=> !(hard_fault && (hard_fault_id == $past(hard_fault_id))));
    assert_distinct_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_map[1:0] != slot_map[3:2]) && (slot_map[1:0] != slot_map[5:4]) && (slot_map[3:2] != slot_map[5:4]));
    assert_degraded_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        degraded |=> degraded && $stable(slot_map));
    assert_unrec_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (degraded || no_majority) |-> unrecoverable);
    assert_unrec_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unrecoverable |=> unrecoverable);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vote_valid |-> (rep_mismatch == 4'b0) && !no_majority && !hard_fault);
endmodule

bind tmr_spare_voter tmr_spare_voter_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .vote_out(vote_out), .vote_valid(vote_valid),
    .rep_mismatch(rep_mismatch), .no_majority(no_majority),
    .hard_fault(hard_fault), .hard_fault_id(hard_fault_id),
    .degraded(degraded), .unrecoverable(unrecoverable), .slot_map(slot_map)
);

// File: tb/tmr_spare_voter_test.sv
`timescale 1ns/1ps
module tmr_spare_voter_test;
    localparam int DW = 8;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [CW-1:0] fail_limit = 4'd2;
    logic [DW-1:0] rep_a = '0, rep_b = '0, rep_c = '0, rep_spare = '0;
    logic [DW-1:0] vote_out;
    logic vote_valid, no_majority, hard_fault, degraded, unrecoverable;
    logic [3:0] rep_mismatch;
    logic [1:0] hard_fault_id;
    logic [5:0] slot_map;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_spare_voter #(.DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fail_limit(fail_limit),
        .rep_a(rep_a), .rep_b(rep_b), .rep_c(rep_c), .rep_spare(rep_spare),
        .vote_out(vote_out), .vote_valid(vote_valid), .rep_mismatch(rep_mismatch),
        .no_majority(no_majority), .hard_fault(hard_fault), .hard_fault_id(hard_fault_id),
        .degraded(degraded), .unrecoverable(unrecoverable), .slot_map(slot_map)
    );

    // Behavioural reference model
    int  m_map[3];
    int  m_cnt[4];
    bit  m_faulty[4];
    bit  m_spare_used, m_degr, m_unrec, m_vv, m_nomaj, m_hf;
    int  m_hfid;
    int  m_out;
    bit  m_mis[4];

    always @(posedge clk) begin
        int vals[3];
        int rv[4];
        int maj;
        bit found;
        if (!rst_n) begin
            m_map = '{0, 1, 2};
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_faulty[i] = 0; m_mis[i] = 0; end
            m_spare_used = 0; m_degr = 0; m_unrec = 0; m_vv = 0; m_nomaj = 0;
            m_hf = 0; m_hfid = 0; m_out = 0;
        end else begin
            rv = '{int'(rep_a), int'(rep_b), int'(rep_c), int'(rep_spare)};
            m_hf = 0;
            foreach (m_mis[i]) m_mis[i] = 0;
            m_vv = in_valid;
            m_nomaj = 0;
            if (in_valid) begin
                int trip_r;
                trip_r = -1;
                for (int s = 0; s < 3; s++) vals[s] = rv[m_map[s]];
                found = 0; maj = 0;
                for (int s = 0; s < 3; s++)
                    for (int t = s + 1; t < 3; t++)
                        if (!found && vals[s] == vals[t]) begin found = 1; maj = vals[s]; end
                if (!found) begin
                    m_nomaj = 1; m_unrec = 1;
                end else begin
                    m_out = maj;
                    for (int s = 0; s < 3; s++) begin
                        int r;
                        r = m_map[s];
                        m_mis[r] = (vals[s] != maj);
                        if (!m_faulty[r]) begin
                            if (!m_mis[r]) m_cnt[r] = 0;
                            else if (m_cnt[r] >= int'(fail_limit)) begin m_faulty[r] = 1; trip_r = r; end
                            else m_cnt[r] = m_cnt[r] + 1;
                        end
                    end
                    if (trip_r >= 0) begin
                        m_hf = 1; m_hfid = trip_r;
                        if (!m_spare_used) begin
                            m_spare_used = 1;
                            for (int s = 0; s < 3; s++) if (m_map[s] == trip_r) m_map[s] = 3;
                        end else begin
                            m_degr = 1; m_unrec = 1;
                        end
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int emis, emap;
            emis = {m_mis[3], m_mis[2], m_mis[1], m_mis[0]};
            emap = (m_map[2] << 4) | (m_map[1] << 2) | m_map[0];
            check(vote_valid == m_vv, "R1/R9 vote_valid", vote_valid, m_vv);
            check(int'(vote_out) == m_out, "R1 vote_out", vote_out, m_out);
            check(int'(rep_mismatch) == emis, "R2 rep_mismatch", rep_mismatch, emis);
            check(no_majority == m_nomaj, "R3 no_majority", no_majority, m_nomaj);
            check(hard_fault == m_hf, "R4 R5 hard_fault", hard_fault, m_hf);
            if (m_hf) check(int'(hard_fault_id) == m_hfid, "R5 hard_fault_id", hard_fault_id, m_hfid);
            check(int'(slot_map) == emap, "R6 slot_map", slot_map, emap);
            check(degraded == m_degr, "R7 degraded", degraded, m_degr);
            check(unrecoverable == m_unrec, "R8 unrecoverable", unrecoverable, m_unrec);
        end
    end

    task automatic cyc(input bit v, input int a, input int b, input int c, input int s);
        @(negedge clk);
        in_valid = v; rep_a = a[DW-1:0]; rep_b = b[DW-1:0]; rep_c = c[DW-1:0]; rep_spare = s[DW-1:0];
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(vote_out == 0 && !vote_valid && rep_mismatch == 0 && !hard_fault && !degraded
              && !unrecoverable && !no_majority, "R10 reset outputs", vote_out, 0);
        check(slot_map == 6'b10_01_00, "R10 reset slot_map", slot_map, 6'b10_01_00);
        @(negedge clk); rst_n = 1;
        // R1: all agree on varied data
        for (int i = 0; i < 6; i++) cyc(1, 8'h11 * i, 8'h11 * i, 8'h11 * i, 8'hEE);
        // R2: single dissenter in each slot, counts cleared between
        cyc(1, 8'h5A, 8'h5A, 8'hA5, 0);
        cyc(1, 8'h5B, 8'h3C, 8'h5B, 0);
        cyc(1, 8'hC3, 8'h77, 8'h77, 0);
        cyc(1, 8'h40, 8'h40, 8'h40, 0);
        // R9: idle with garbage
        cyc(0, 1, 2, 3, 4);
        cyc(0, 9, 9, 7, 4);
        // R4: runs of exactly limit mismatches on B, broken by agreement
        cyc(1, 8'h10, 8'hFF, 8'h10, 0);
        cyc(1, 8'h11, 8'hFF, 8'h11, 0);
        cyc(1, 8'h12, 8'h12, 8'h12, 0);
        cyc(1, 8'h13, 8'hFF, 8'h13, 0);
        cyc(1, 8'h14, 8'hFF, 8'h14, 0);
        cyc(0, 0, 0, 0, 0);
        // R4/R5/R6: third consecutive mismatch trips B; spare takes slot 1
        cyc(1, 8'h15, 8'hFF, 8'h15, 8'h15);
        cyc(1, 8'h16, 8'h00, 8'h16, 8'h16);
        // R2/R6: removed copy is ignored, spare votes
        cyc(1, 8'h20, 8'hAB, 8'h20, 8'h20);
        cyc(1, 8'h21, 8'h21, 8'h21, 8'h99);
        cyc(1, 8'h22, 8'h01, 8'h22, 8'h22);
        @(negedge clk);
        check(slot_map == 6'b10_11_00, "R6 spare in slot 1", slot_map, 6'b10_11_00);
        // R3/R8: no majority holds output and latches unrecoverable
        cyc(1, 8'h31, 8'h00, 8'h32, 8'h33);
        cyc(1, 8'h40, 8'h00, 8'h40, 8'h40);
        // two copies share a wrong value: wrong value wins, correct copy flagged
        cyc(1, 8'h66, 8'h00, 8'h50, 8'h66);
        cyc(1, 8'h51, 8'h00, 8'h51, 8'h51);
        // R7: limit 0, copy A fails once -> second hard failure, degraded
        fail_limit = 4'd0;
        cyc(1, 8'h70, 8'h00, 8'h71, 8'h71);
        cyc(1, 8'h72, 8'h00, 8'h73, 8'h73);
        cyc(1, 8'h74, 8'h00, 8'h74, 8'h74);
        cyc(0, 0, 0, 0, 0);
        @(negedge clk);
        check(degraded && slot_map == 6'b10_11_00, "R7 degraded map kept", slot_map, 6'b10_11_00);
        // R10: reset again clears sticky flags
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        check(!degraded && !unrecoverable && slot_map == 6'b10_01_00, "R10 re-reset", slot_map, 6'b10_01_00);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule